// File: doc/BRIEF.md
# Chess Square Colour Classifier

This block turns a stream of colour samples from an overhead camera into a map of piece colours on an 8x8 board. Each accepted sample carries a luma value, two chroma values and its x/y position in the frame. A sample is counted only when it lies inside the inspection window of one board square. Each window is the span between a column's left and right x limits crossed with a row's top and bottom y limits. Counted samples are sorted into four colour classes: red marker (dark-side piece), green marker (light-side piece), dark board surface and light board surface. Each class is judged against its own reference values, widened by a shared tolerance.

Each square keeps one saturating counter per colour class. When a frame closes, every square gets a 2-bit verdict from its strongest class. An error verdict covers a tie for the lead and a lead count below a programmable floor, as happens when a hand hides part of the board. The 64 verdicts are captured together into four 32-bit result words, which a small read port selects by index. A one-cycle done pulse marks the moment the new words are in place. Software polls the words and compares them with the previous position.

Top module: `chess_square_classifier`

## Requirements
- R1: After reset all four result words read zero (every square empty) and done_o is low.
- R2: A sample with pix_valid_i high is counted for square (row r, column c) only when col_lo[c] <= x <= col_hi[c] and row_lo[r] <= y <= row_hi[r], bounds inclusive; any sample outside every window changes no counter.
- R3: A sample is red when cr + tol >= red_cr_ref; luma and cb play no part, and red takes precedence over every other class.
- R4: A sample that is not red is green when luma + tol >= grn_y_ref and |cr - cb| <= tol.
- R5: A sample that is neither red nor green is dark when luma, cb and cr each lie within tol of the dark references, else light when each lies within tol of the light references; a sample matching no class changes no counter.
- R6: At frame end a square's code is 01 when red leads, 10 when green leads, 00 when dark or light leads, and 11 when two or more classes share the highest count or that count is below min_count_i.
- R7: Each per-square class counter stops at 255 (2^CW-1) and never wraps.
- R8: frame_start_i clears every counter; a sample accepted in the same cycle is counted into the new frame.
- R9: A sample accepted in the same cycle as frame_end_i is included in the verdict; the result words change only on the clock edge that samples frame_end_i, and done_o is high for exactly the following cycle.
- R10: Word rd_addr_i = r/2 holds square (r, c) in bits [2c+1:2c] for even r and in bits [2c+17:2c+16] for odd r, and rd_data_o shows the selected word without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| frame_start_i | input | 1 | Clears all square counters |
| frame_end_i | input | 1 | Closes the frame and captures the verdicts |
| pix_valid_i | input | 1 | Sample present this cycle |
| pix_x_i | input | XW | Sample x position |
| pix_y_i | input | YW | Sample y position |
| luma_i | input | PW | Sample luma |
| cb_i | input | PW | Sample blue-difference chroma |
| cr_i | input | PW | Sample red-difference chroma |
| col_lo_i | input | 8*XW | Left x limit per column, column c at bits [c*XW +: XW] |
| col_hi_i | input | 8*XW | Right x limit per column |
| row_lo_i | input | 8*YW | Top y limit per row, row r at bits [r*YW +: YW] |
| row_hi_i | input | 8*YW | Bottom y limit per row |
| red_cr_ref_i | input | PW | Red marker chroma threshold |
| grn_y_ref_i | input | PW | Green marker luma threshold |
| dark_y_ref_i | input | PW | Dark surface luma reference |
| dark_cb_ref_i | input | PW | Dark surface cb reference |
| dark_cr_ref_i | input | PW | Dark surface cr reference |
| light_y_ref_i | input | PW | Light surface luma reference |
| light_cb_ref_i | input | PW | Light surface cb reference |
| light_cr_ref_i | input | PW | Light surface cr reference |
| tol_i | input | PW | Tolerance applied to every comparison |
| min_count_i | input | CW | Lowest winning count that is not an error |
| rd_addr_i | input | 2 | Result word select |
| rd_data_o | output | 32 | Selected result word |
| done_o | output | 1 | One-cycle pulse after the words update |

## Verification
Counting a sample and deciding the verdicts can happen in the same cycle. The bench closes frames with a sample still valid on the frame_end_i cycle, choosing a square whose count then reaches min_count_i only if that last sample is counted, so its expected code depends on inclusion. The same overlap is provoked at the other end by a sample that arrives together with frame_start_i after a frame that left counts behind. It is also covered by random frames that open and close this way. In every case the words read back after done_o are compared with a bench model of counters and verdicts.

// File: rtl/chess_cls_pkg.sv
package chess_cls_pkg;

  localparam int BOARD   = 8;
  localparam int SQUARES = BOARD * BOARD;
  localparam int NCLS    = 4;
  localparam int IDX_W   = $clog2(BOARD);
  localparam int WORD_W  = 4 * BOARD;
  localparam int NWORDS  = BOARD / 2;
  localparam int HALF_W  = WORD_W / 2;

  typedef enum logic [1:0] {
    CLS_RED   = 2'd0,
    CLS_GREEN = 2'd1,
    CLS_DARK  = 2'd2,
    CLS_LIGHT = 2'd3
  } pix_cls_e;

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_BLACK = 2'b01;
  localparam logic [1:0] ST_WHITE = 2'b10;
  localparam logic [1:0] ST_ERR   = 2'b11;

endpackage

// File: rtl/sq_locator.sv
module sq_locator
  import chess_cls_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic [XW-1:0]       x_i,
  input  logic [YW-1:0]       y_i,
  input  logic [BOARD*XW-1:0] col_lo_i,
  input  logic [BOARD*XW-1:0] col_hi_i,
  input  logic [BOARD*YW-1:0] row_lo_i,
  input  logic [BOARD*YW-1:0] row_hi_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    row_o,
  output logic [IDX_W-1:0]    col_o
);

  logic col_hit, row_hit;

  // Scan downwards so the lowest matching index is the one kept.
  always_comb begin
    col_hit = 1'b0;
    col_o   = '0;
    for (int c = BOARD - 1; c >= 0; c--) begin
      if (x_i >= col_lo_i[c*XW +: XW] && x_i <= col_hi_i[c*XW +: XW]) begin
        col_hit = 1'b1;
        col_o   = IDX_W'(c);
      end
    end
  end

  always_comb begin
    row_hit = 1'b0;
    row_o   = '0;
    for (int r = BOARD - 1; r >= 0; r--) begin
      if (y_i >= row_lo_i[r*YW +: YW] && y_i <= row_hi_i[r*YW +: YW]) begin
        row_hit = 1'b1;
        row_o   = IDX_W'(r);
      end
    end
  end

  assign hit_o = col_hit & row_hit;

endmodule

// File: rtl/pix_classifier.sv
module pix_classifier
  import chess_cls_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic [PW-1:0] luma_i,
  input  logic [PW-1:0] cb_i,
  input  logic [PW-1:0] cr_i,
  input  logic [PW-1:0] red_cr_ref_i,
  input  logic [PW-1:0] grn_y_ref_i,
  input  logic [PW-1:0] dark_y_ref_i,
  input  logic [PW-1:0] dark_cb_ref_i,
  input  logic [PW-1:0] dark_cr_ref_i,
  input  logic [PW-1:0] light_y_ref_i,
  input  logic [PW-1:0] light_cb_ref_i,
  input  logic [PW-1:0] light_cr_ref_i,
  input  logic [PW-1:0] tol_i,
  output logic          hit_o,
  output pix_cls_e      cls_o
);

  function automatic logic [PW-1:0] adiff(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  logic is_red, is_green, is_dark, is_light;

  always_comb begin
    is_red   = ({1'b0, cr_i} + {1'b0, tol_i}) >= {1'b0, red_cr_ref_i};
    is_green = (({1'b0, luma_i} + {1'b0, tol_i}) >= {1'b0, grn_y_ref_i}) &&
               (adiff(cr_i, cb_i) <= tol_i);
    is_dark  = (adiff(luma_i, dark_y_ref_i) <= tol_i) &&
               (adiff(cb_i, dark_cb_ref_i) <= tol_i) &&
               (adiff(cr_i, dark_cr_ref_i) <= tol_i);
    is_light = (adiff(luma_i, light_y_ref_i) <= tol_i) &&
               (adiff(cb_i, light_cb_ref_i) <= tol_i) &&
               (adiff(cr_i, light_cr_ref_i) <= tol_i);
  end

  // Fixed precedence: red, green, dark, light.
  always_comb begin
    hit_o = 1'b1;
    if (is_red)        cls_o = CLS_RED;
    else if (is_green) cls_o = CLS_GREEN;
    else if (is_dark)  cls_o = CLS_DARK;
    else if (is_light) cls_o = CLS_LIGHT;
    else begin
      cls_o = CLS_RED;
      hit_o = 1'b0;
    end
  end

endmodule

// File: rtl/sq_tally.sv
module sq_tally
  import chess_cls_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  input  pix_cls_e      cls_i,
  input  logic [CW-1:0] min_i,
  output logic [1:0]    state_o
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q [NCLS];
  logic [CW-1:0] cnt_d [NCLS];
  logic          cnt_en;
  logic [CW-1:0] base;
  logic [CW-1:0] best;
  logic [1:0]    best_k;
  logic [2:0]    n_top;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    for (int k = 0; k < NCLS; k++) begin
      base     = clr_i ? '0 : cnt_q[k];
      cnt_d[k] = (inc_i && cls_i == pix_cls_e'(k) && base != CMAX) ? base + 1'b1 : base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCLS; k++) cnt_q[k] <= '0;
    end else if (cnt_en) begin
      for (int k = 0; k < NCLS; k++) cnt_q[k] <= cnt_d[k];
    end
  end

  // Verdict is taken from the next-state counts so a sample in the
  // closing cycle is part of the decision.
  always_comb begin
    best   = cnt_d[0];
    best_k = 2'd0;
    for (int k = 1; k < NCLS; k++) begin
      if (cnt_d[k] > best) begin
        best   = cnt_d[k];
        best_k = 2'(k);
      end
    end
    n_top = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (cnt_d[k] == best) n_top = n_top + 3'd1;
    end
    if (n_top != 3'd1 || best < min_i) begin
      state_o = ST_ERR;
    end else begin
      case (pix_cls_e'(best_k))
        CLS_RED:   state_o = ST_BLACK;
        CLS_GREEN: state_o = ST_WHITE;
        default:   state_o = ST_EMPTY;
      endcase
    end
  end

  for (genvar k = 0; k < NCLS; k++) begin : g_chk
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[k] == CMAX && !clr_i) |=> (cnt_q[k] == CMAX));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q[k] <= CW'(1)));
  end

endmodule

// File: rtl/chess_square_classifier.sv
module chess_square_classifier
  import chess_cls_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic                frame_end_i,
  input  logic                pix_valid_i,
  input  logic [XW-1:0]       pix_x_i,
  input  logic [YW-1:0]       pix_y_i,
  input  logic [PW-1:0]       luma_i,
  input  logic [PW-1:0]       cb_i,
  input  logic [PW-1:0]       cr_i,
  input  logic [8*XW-1:0]     col_lo_i,
  input  logic [8*XW-1:0]     col_hi_i,
  input  logic [8*YW-1:0]     row_lo_i,
  input  logic [8*YW-1:0]     row_hi_i,
  input  logic [PW-1:0]       red_cr_ref_i,
  input  logic [PW-1:0]       grn_y_ref_i,
  input  logic [PW-1:0]       dark_y_ref_i,
  input  logic [PW-1:0]       dark_cb_ref_i,
  input  logic [PW-1:0]       dark_cr_ref_i,
  input  logic [PW-1:0]       light_y_ref_i,
  input  logic [PW-1:0]       light_cb_ref_i,
  input  logic [PW-1:0]       light_cr_ref_i,
  input  logic [PW-1:0]       tol_i,
  input  logic [CW-1:0]       min_count_i,
  input  logic [1:0]          rd_addr_i,
  output logic [31:0]         rd_data_o,
  output logic                done_o
);

  // Reset: asserted at once, released after two clock edges.
  logic rst_s0, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_core_n <= rst_s0;
    end
  end

  logic             loc_hit;
  logic [IDX_W-1:0] loc_row, loc_col;
  logic             cls_hit;
  pix_cls_e         cls;
  logic             take;

  sq_locator #(.XW(XW), .YW(YW)) u_loc (
    .x_i      (pix_x_i),
    .y_i      (pix_y_i),
    .col_lo_i (col_lo_i),
    .col_hi_i (col_hi_i),
    .row_lo_i (row_lo_i),
    .row_hi_i (row_hi_i),
    .hit_o    (loc_hit),
    .row_o    (loc_row),
    .col_o    (loc_col)
  );

  pix_classifier #(.PW(PW)) u_cls (
    .luma_i         (luma_i),
    .cb_i           (cb_i),
    .cr_i           (cr_i),
    .red_cr_ref_i   (red_cr_ref_i),
    .grn_y_ref_i    (grn_y_ref_i),
    .dark_y_ref_i   (dark_y_ref_i),
    .dark_cb_ref_i  (dark_cb_ref_i),
    .dark_cr_ref_i  (dark_cr_ref_i),
    .light_y_ref_i  (light_y_ref_i),
    .light_cb_ref_i (light_cb_ref_i),
    .light_cr_ref_i (light_cr_ref_i),
    .tol_i          (tol_i),
    .hit_o          (cls_hit),
    .cls_o          (cls)
  );

  assign take = pix_valid_i & loc_hit & cls_hit;

  logic [SQUARES-1:0][1:0] sq_state;

  for (genvar r = 0; r < BOARD; r++) begin : g_row
    for (genvar c = 0; c < BOARD; c++) begin : g_col
      logic sq_inc;
      assign sq_inc = take & (loc_row == IDX_W'(r)) & (loc_col == IDX_W'(c));
      sq_tally #(.CW(CW)) u_sq (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .clr_i   (frame_start_i),
        .inc_i   (sq_inc),
        .cls_i   (cls),
        .min_i   (min_count_i),
        .state_o (sq_state[r*BOARD + c])
      );
    end
  end

  // Even row in the low half of a word, odd row in the high half.
  logic [NWORDS-1:0][WORD_W-1:0] words_d, words_q;
  always_comb begin
    words_d = '0;
    for (int r = 0; r < BOARD; r++) begin
      for (int c = 0; c < BOARD; c++) begin
        words_d[r/2][2*c + HALF_W*(r%2) +: 2] = sq_state[r*BOARD + c];
      end
    end
  end

  logic done_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      words_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_end_i;
      if (frame_end_i) words_q <= words_d;
    end
  end

  assign done_o    = done_q;
  assign rd_data_o = words_q[rd_addr_i];

  p_done_after_end_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_end_i |=> done_o);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !frame_end_i |=> !done_o);
  p_words_hold_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !frame_end_i |=> $stable(words_q));

endmodule

// File: tb/tb_chess_square_classifier.sv
module tb_chess_square_classifier;

  localparam int XW = 10, YW = 9, PW = 8, CW = 8;
  localparam int RED_REF = 200, GRN_REF = 180;
  localparam int DY = 40, DB = 128, DR = 128;
  localparam int LY = 150, LB = 128, LR = 128;
  localparam int CMAX = 255;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fs, fe, pv;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  logic [PW-1:0] lu, cb, cr, tol_v;
  logic [CW-1:0] minc_v;
  logic [8*XW-1:0] col_lo, col_hi;
  logic [8*YW-1:0] row_lo, row_hi;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        done;

  chess_square_classifier #(.XW(XW), .YW(YW), .PW(PW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .frame_end_i(fe),
    .pix_valid_i(pv), .pix_x_i(px_x), .pix_y_i(px_y),
    .luma_i(lu), .cb_i(cb), .cr_i(cr),
    .col_lo_i(col_lo), .col_hi_i(col_hi), .row_lo_i(row_lo), .row_hi_i(row_hi),
    .red_cr_ref_i(8'(RED_REF)), .grn_y_ref_i(8'(GRN_REF)),
    .dark_y_ref_i(8'(DY)), .dark_cb_ref_i(8'(DB)), .dark_cr_ref_i(8'(DR)),
    .light_y_ref_i(8'(LY)), .light_cb_ref_i(8'(LB)), .light_cr_ref_i(8'(LR)),
    .tol_i(tol_v), .min_count_i(minc_v),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .done_o(done)
  );

  int n_vec = 0, n_err = 0;
  int tol, minc;
  int cnt [64][4];
  logic [31:0] exp_w [4];
  int clo [8], chi [8], rlo [8], rhi [8];

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Class per R3, R4, R5: 1 red, 2 green, 3 dark, 4 light, 0 none
  function automatic int classify(int l, int b, int r);
    if (r + tol >= RED_REF) return 1;
    if (l + tol >= GRN_REF && absd(r, b) <= tol) return 2;
    if (absd(l, DY) <= tol && absd(b, DB) <= tol && absd(r, DR) <= tol) return 3;
    if (absd(l, LY) <= tol && absd(b, LB) <= tol && absd(r, LR) <= tol) return 4;
    return 0;
  endfunction

  // Square index per R2, or -1
  function automatic int locate(int x, int y);
    int cc = -1, rr = -1;
    for (int c = 7; c >= 0; c--) if (x >= clo[c] && x <= chi[c]) cc = c;
    for (int r = 7; r >= 0; r--) if (y >= rlo[r] && y <= rhi[r]) rr = r;
    if (cc < 0 || rr < 0) return -1;
    return rr * 8 + cc;
  endfunction

  // Code per R6
  function automatic int verdict(int sq);
    int mx = 0, mk = 0, nt = 0;
    for (int k = 0; k < 4; k++) if (cnt[sq][k] > mx) begin mx = cnt[sq][k]; mk = k; end
    for (int k = 0; k < 4; k++) if (cnt[sq][k] == mx) nt++;
    if (nt != 1 || mx < minc) return 3;
    if (mk == 0) return 1;
    if (mk == 1) return 2;
    return 0;
  endfunction

  // Packing per R10
  task automatic compute_exp();
    for (int w = 0; w < 4; w++) exp_w[w] = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        exp_w[r/2][2*c + 16*(r%2) +: 2] = 2'(verdict(r*8 + c));
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_words(input string req);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check(req, rd_data, exp_w[a]);
    end
  endtask

  task automatic set_cfg(input int t, input int m);
    tol = t; minc = m;
    tol_v = 8'(t); minc_v = 8'(m);
  endtask

  // One cycle of stimulus; called right after a falling edge.
  task automatic px(input int x, input int y, input int l, input int b, input int r,
                    input bit v, input bit s, input bit e);
    int sq, k;
    pv = v; fs = s; fe = e;
    px_x = XW'(x); px_y = YW'(y); lu = 8'(l); cb = 8'(b); cr = 8'(r);
    if (s) for (int q = 0; q < 64; q++) for (int j = 0; j < 4; j++) cnt[q][j] = 0;
    if (v) begin
      sq = locate(x, y);
      k  = classify(l, b, r);
      if (sq >= 0 && k > 0 && cnt[sq][k-1] < CMAX) cnt[sq][k-1]++;
    end
    if (e) compute_exp();
    @(negedge clk);
    pv = 1'b0; fs = 1'b0; fe = 1'b0;
  endtask

  task automatic put(input int r, input int c, input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      int x = clo[c] + $urandom_range(0, chi[c] - clo[c]);
      int y = rlo[r] + $urandom_range(0, rhi[r] - rlo[r]);
      case (kind)
        1: px(x, y, 90, 100, 220, 1, 0, 0);
        2: px(x, y, 200, 110, 110, 1, 0, 0);
        3: px(x, y, DY, DB, DR, 1, 0, 0);
        default: px(x, y, LY, LB, LR, 1, 0, 0);
      endcase
    end
  endtask

  // Random sample near the class boundaries
  task automatic rand_px(input bit s, input bit e);
    int x = $urandom_range(0, 359), y = $urandom_range(0, 259);
    int l, b, r;
    case ($urandom_range(0, 4))
      0: begin l = $urandom_range(0, 255); b = $urandom_range(0, 255); r = $urandom_range(0, 255); end
      1: begin l = 90; b = 100; r = RED_REF - tol - 2 + $urandom_range(0, 4); end
      2: begin l = GRN_REF - tol - 1 + $urandom_range(0, 2); b = 110; r = 110 + $urandom_range(0, tol + 2); end
      3: begin l = DY - tol - 1 + $urandom_range(0, 2*tol + 2); b = DB - 1 + $urandom_range(0, 2); r = DR; end
      default: begin l = LY - tol - 1 + $urandom_range(0, 2*tol + 2); b = LB; r = LR + 1 - $urandom_range(0, 2); end
    endcase
    px(x, y, l, b, r, 1, s, e);
  endtask

  task automatic after_end(input string req);
    check({req, " R9 done high"}, {31'd0, done}, 32'd1);
    check_words({req, " R6 R10 words"});
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin
      clo[i] = 20 + 40*i; chi[i] = clo[i] + 29;
      rlo[i] = 10 + 30*i; rhi[i] = rlo[i] + 19;
      col_lo[i*XW +: XW] = XW'(clo[i]); col_hi[i*XW +: XW] = XW'(chi[i]);
      row_lo[i*YW +: YW] = YW'(rlo[i]); row_hi[i*YW +: YW] = YW'(rhi[i]);
    end
    for (int q = 0; q < 64; q++) for (int j = 0; j < 4; j++) cnt[q][j] = 0;
    rst_n = 1'b0; pv = 0; fs = 0; fe = 0; px_x = '0; px_y = '0;
    lu = '0; cb = '0; cr = '0; rd_addr = '0;
    set_cfg(8, 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int w = 0; w < 4; w++) exp_w[w] = '0;
    check("R1 done low", {31'd0, done}, 32'd0);
    check_words("R1 reset words");

    // R7: saturation frame; 300 red and 260 green tie at 255 -> error
    px(0, 0, 0, 0, 0, 0, 1, 0);
    put(2, 3, 1, 300);
    put(2, 3, 2, 260);
    put(6, 1, 3, 4);
    px(0, 0, 0, 0, 0, 0, 0, 1);
    after_end("R7 saturation");

    // Directed frame; R8 opening sample lands in a square with stale counts
    px(clo[3] + 2, rlo[2] + 2, 200, 110, 110, 1, 1, 0);
    put(2, 3, 2, 3);                 // green 4 -> 10 only if cleared (R8)
    put(0, 0, 1, 9); put(0, 0, 3, 3); // R6 red leads -> 01
    put(1, 1, 2, 6);                  // R4 green -> 10
    put(2, 2, 3, 5); put(2, 2, 4, 2); // R5 dark -> 00
    put(3, 3, 4, 4);                  // R5 light -> 00
    put(4, 4, 1, 4); put(4, 4, 2, 4); // R6 tie -> 11
    put(4, 5, 1, 2);                  // R6 below floor -> 11
    put(5, 5, 1, 2);
    for (int i = 0; i < 3; i++) px(clo[6] + 5, rlo[6] + 5, 90, 100, RED_REF - 8, 1, 0, 0);  // R3 at edge
    for (int i = 0; i < 3; i++) px(clo[7] + 5, rlo[6] + 5, 90, 100, RED_REF - 9, 1, 0, 0);  // R3 just outside
    for (int i = 0; i < 6; i++) px(chi[7] + 4, rlo[7] + 3, 90, 100, 220, 1, 0, 0);         // R2 right of last column
    for (int i = 0; i < 6; i++) px(clo[7] + 3, rhi[6] + 4, 90, 100, 220, 1, 0, 0);         // R2 row gap
    for (int i = 0; i < 6; i++) px(clo[7] + 3, rlo[7] + 3, 90, 100, 220, 0, 0, 0);         // R2 not valid
    put(7, 7, 2, 3);
    // R9: third red sample arrives with frame_end and lifts (5,5) to the floor
    px(clo[5] + 1, rlo[5] + 1, 90, 100, 220, 1, 0, 1);
    after_end("R9 coincident end");

    // Floor of zero: untouched squares tie at zero and stay error
    set_cfg(4, 0);
    px(clo[1], rlo[1], LY, LB, LR, 1, 1, 0);
    put(0, 7, 2, 1);
    px(clo[0], rhi[0], DY + 4, DB - 4, DR + 4, 1, 0, 1);
    after_end("R5 R6 floor zero");

    // Random frames
    for (int f = 0; f < 6; f++) begin
      set_cfg(4 + 4*(f % 3), 1 + (f % 4));
      rand_px(1, 0);
      for (int i = 0; i < 700; i++) rand_px(0, 0);
      check("R9 done idle mid-frame", {31'd0, done}, 32'd0);
      check_words("R9 words hold mid-frame");
      for (int i = 0; i < 700; i++) rand_px(0, 0);
      rand_px(0, 1);
      after_end("R2 R3 R4 R5 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule